// File: doc/BRIEF.md
# PCI-to-ISA Interrupt Router

The router collects level-sensitive interrupt requests from the on-chip functions and from four external PCI interrupt pins. It steers each request onto one of sixteen ISA interrupt request lines. For every line it keeps a bitmap of the sources that have driven that line active. The line is high whenever its bitmap holds any set bit. A separate global record holds the present level of every source.

On-chip function `n` reports its level on `func_level[n]`. Its line number is an 8-bit value in byte `n` of `func_line`. The four external pins take their line numbers from 4-bit routing fields in three configuration bytes. Level changes are taken one per clock cycle, lowest source slot first. An update writes the source's bit into the bitmap of its target line. It then masks that bitmap with the global record, which removes any bit a source left behind when its routing was changed earlier. The interrupt controller that consumes the sixteen lines sits outside this block.

Top module: `irqr_router`

## Requirements
- R1: After a synchronous active-low reset all sixteen outputs are low and no source is recorded active.
- R2: On-chip function `n` uses source slot `n` and the line number in `func_line[8n+7:8n]`. One cycle after its level change is taken, `isa_irq[line]` shows the new state.
- R3: External pins use slots 8 to 11. Pin A (`pin_level[0]`) takes its line from `rt_cfg_lo[7:4]`. Pin B (`pin_level[1]`) takes its line from `rt_cfg_mid[3:0]`. Pin C (`pin_level[2]`) takes its line from `rt_cfg_mid[7:4]`. Pin D (`pin_level[3]`) takes its line from `rt_cfg_hi[7:4]`. Bits `rt_cfg_lo[3:0]` and `rt_cfg_hi[3:0]` have no effect.
- R4: A line number of 0 or 0xFF disables the source, and no output changes.
- R5: A line number of 2 is rejected, and no output changes.
- R6: Functions 2, 3 and 5 accept line numbers up to 14. All other sources accept line numbers up to 15. A number above the ceiling is rejected, and no output changes.
- R7: Every level change updates the global record, whether or not its routing is valid. After a valid update to line `k`, the bitmap of `k` is masked with the global record. A bit left on an old line after a re-route therefore stays until the next update that targets that line, and is cleared then.
- R8: At most one level change is taken per cycle, and the lowest pending slot goes first. Changes arriving together therefore appear on the outputs on successive cycles.
- R9: A line stays high while any source whose bit is in its bitmap is still active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| func_level | input | NUM_FUNC | Request level of each on-chip function |
| func_line | input | NUM_FUNC*8 | Line number of each on-chip function, one byte per function |
| pin_level | input | 4 | Levels of external pins A to D |
| rt_cfg_lo | input | 8 | Routing byte; bits [7:4] hold the line number for pin A |
| rt_cfg_mid | input | 8 | Routing byte; bits [3:0] hold the line number for pin B, bits [7:4] the line number for pin C |
| rt_cfg_hi | input | 8 | Routing byte; bits [7:4] hold the line number for pin D |
| isa_irq | output | 16 | ISA interrupt request levels |

## Verification
The bench raises several sources in the same cycle and checks that they reach the outputs one cycle apart, in slot order. An arbiter with the wrong priority, or one that merged changes, would light the lines in the wrong order or all at once. It re-routes an active source and then drops it. The old line must stay high until another source updates that line and the mask clears the stale bit. A router without the mask would leave the line stuck high, and one that cleared every line eagerly would drop it too soon. Line numbers 0, 0xFF and 2, and a value of 15 on a function whose ceiling is 14, must leave every output low. Decoding that treated any of these as a real line would raise a spurious request.

// File: rtl/irqr_pkg.sv
// Shared constants and the line-number check for the interrupt router.
// Assumes line numbers are 8 bits wide and that sixteen ISA lines exist.
package irqr_pkg;
    localparam int LINE_W    = 8;
    localparam int NUM_LINES = 16;
    localparam int NUM_PINS  = 4;

    // Returns 1 when a line number may be written into a line bitmap.
    function automatic logic line_valid(input logic [LINE_W-1:0] num,
                                        input logic low_ceiling);
        logic [LINE_W-1:0] top;
        top = low_ceiling ? LINE_W'(14) : LINE_W'(15);
        return (num != '0) && (num != '1) && (num != LINE_W'(2)) && (num <= top);
    endfunction
endpackage

// File: rtl/irqr_line_sel.sv
// Builds the per-slot line-number table.
// Functions take slots 0..NUM_FUNC-1 and pins take the slots after them.
// Assumes exactly four pins, with fixed nibble positions in the routing bytes.
module irqr_line_sel
    import irqr_pkg::*;
#(
    parameter int NUM_FUNC = 8,
    localparam int NUM_SRC = NUM_FUNC + NUM_PINS
) (
    input  logic [NUM_FUNC*LINE_W-1:0] func_line,
    input  logic [7:0]                 rt_cfg_lo,
    input  logic [7:0]                 rt_cfg_mid,
    input  logic [7:0]                 rt_cfg_hi,
    output logic [NUM_SRC*LINE_W-1:0]  src_line
);
    logic unused_route_bits;
    assign unused_route_bits = ^{rt_cfg_lo[3:0], rt_cfg_hi[3:0]};

    // Each function's own line number passes straight through.
    genvar f;
    generate
        for (f = 0; f < NUM_FUNC; f++) begin : g_func
            assign src_line[f*LINE_W +: LINE_W] = func_line[f*LINE_W +: LINE_W];
        end
    endgenerate

    // Pin line numbers come from the routing nibbles, zero-extended.
    assign src_line[(NUM_FUNC+0)*LINE_W +: LINE_W] = {4'h0, rt_cfg_lo[7:4]};
    assign src_line[(NUM_FUNC+1)*LINE_W +: LINE_W] = {4'h0, rt_cfg_mid[3:0]};
    assign src_line[(NUM_FUNC+2)*LINE_W +: LINE_W] = {4'h0, rt_cfg_mid[7:4]};
    assign src_line[(NUM_FUNC+3)*LINE_W +: LINE_W] = {4'h0, rt_cfg_hi[7:4]};
endmodule

// File: rtl/irqr_pick.sv
// Fixed-priority picker: selects the lowest-numbered pending slot.
// Assumes the caller takes exactly one change per cycle when any is pending.
module irqr_pick #(
    parameter int N = 12,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so that the lowest pending slot wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end

    // Flags that at least one change is waiting.
    assign any = |pend;
endmodule

// File: rtl/irqr_state.sv
// Holds the global source record and one source bitmap per ISA line.
// Each output is the OR of its line's bitmap.
// Assumes at most one update per cycle, carrying slot, level, line and validity.
module irqr_state
    import irqr_pkg::*;
#(
    parameter int N = 12,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic [IDX_W-1:0]     upd_idx,
    input  logic                 upd_lvl,
    input  logic [LINE_W-1:0]    upd_line,
    input  logic                 upd_ok,
    output logic [NUM_LINES-1:0] line_or
);
    logic [N-1:0] glob;
    logic [N-1:0] glob_nxt;
    logic [N-1:0] bm [NUM_LINES];

    // Global record with the incoming slot bit replaced by its new level.
    always_comb begin
        glob_nxt = glob;
        glob_nxt[upd_idx] = upd_lvl;
    end

    // The global record follows every level change, valid route or not.
    always_ff @(posedge clk) begin
        if (!rst_n)   glob <= '0;
        else if (upd) glob <= glob_nxt;
    end

    genvar k;
    generate
        for (k = 0; k < NUM_LINES; k++) begin : g_line
            logic [N-1:0] bm_set;
            // Write the slot bit into this line's bitmap, then mask it with the new global record.
            always_comb begin
                bm_set = bm[k];
                bm_set[upd_idx] = upd_lvl;
            end
            // The bitmap is updated only by a valid update aimed at this line.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bm[k] <= '0;
                else if (upd && upd_ok && upd_line == LINE_W'(k))
                    bm[k] <= bm_set & glob_nxt;
            end
            assign line_or[k] = |bm[k];
        end
    endgenerate

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(line_or)); // R8

    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !upd_ok) |=> $stable(line_or)); // R5

    AST_SET_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && upd_ok && upd_lvl) |=> line_or[$past(upd_line[3:0])]); // R2

    AST_STALE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && upd_ok) |=> ((bm[$past(upd_line[3:0])] & ~glob) == '0)); // R7
endmodule

// File: rtl/irqr_router.sv
// Top of the interrupt router.
// A change is seen when a source level differs from the level last taken.
// One change is taken per cycle, lowest slot first, and sent to the state array.
// Assumes all inputs are synchronous to clk.
module irqr_router
    import irqr_pkg::*;
#(
    parameter int NUM_FUNC = 8,
    parameter logic [NUM_FUNC+NUM_PINS-1:0] LOW_CEIL_SRC = 12'h02C,
    localparam int NUM_SRC = NUM_FUNC + NUM_PINS,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_FUNC-1:0]         func_level,
    input  logic [NUM_FUNC*LINE_W-1:0]  func_line,
    input  logic [NUM_PINS-1:0]         pin_level,
    input  logic [7:0]                  rt_cfg_lo,
    input  logic [7:0]                  rt_cfg_mid,
    input  logic [7:0]                  rt_cfg_hi,
    output logic [NUM_LINES-1:0]        isa_irq
);
    logic [NUM_SRC-1:0]        lvl;
    logic [NUM_SRC-1:0]        seen;
    logic [NUM_SRC-1:0]        pend;
    logic [NUM_SRC*LINE_W-1:0] src_line;
    logic                      any;
    logic                      upd;
    logic [IDX_W-1:0]          idx;
    logic [LINE_W-1:0]         sel_line;
    logic                      sel_ok;

    assign lvl  = {pin_level, func_level};
    assign pend = lvl ^ seen;
    assign upd  = any && rst_n;

    irqr_line_sel #(.NUM_FUNC(NUM_FUNC)) u_sel (
        .func_line (func_line),
        .rt_cfg_lo (rt_cfg_lo),
        .rt_cfg_mid(rt_cfg_mid),
        .rt_cfg_hi (rt_cfg_hi),
        .src_line  (src_line)
    );

    irqr_pick #(.N(NUM_SRC)) u_pick (
        .pend(pend),
        .any (any),
        .idx (idx)
    );

    // Line number and validity of the slot being taken this cycle.
    always_comb begin
        sel_line = src_line[idx*LINE_W +: LINE_W];
        sel_ok   = line_valid(sel_line, LOW_CEIL_SRC[idx]);
    end

    // Records the level last taken for each slot.
    always_ff @(posedge clk) begin
        if (!rst_n)   seen <= '0;
        else if (upd) seen[idx] <= lvl[idx];
    end

    irqr_state #(.N(NUM_SRC)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .upd_idx (idx),
        .upd_lvl (lvl[idx]),
        .upd_line(sel_line),
        .upd_ok  (sel_ok),
        .line_or (isa_irq)
    );

    AST_ONE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> ($countones(seen ^ $past(seen)) == 1)); // R8

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> ((pend & ((NUM_SRC'(1) << idx) - NUM_SRC'(1))) == '0)); // R8
endmodule

// File: tb/irqr_router_test.sv
// Bench for irqr_router: a behavioural reference model that is checked every cycle, plus directed checks.
module irqr_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  func_level = '0;
    logic [63:0] func_line = '0;
    logic [3:0]  pin_level = '0;
    logic [7:0]  rt_cfg_lo = '0;
    logic [7:0]  rt_cfg_mid = '0;
    logic [7:0]  rt_cfg_hi = '0;
    logic [15:0] isa_irq;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    bit model_on = 0;

    always #4 clk = ~clk;

    irqr_router uut (
        .clk(clk), .rst_n(rst_n), .func_level(func_level), .func_line(func_line),
        .pin_level(pin_level), .rt_cfg_lo(rt_cfg_lo), .rt_cfg_mid(rt_cfg_mid),
        .rt_cfg_hi(rt_cfg_hi), .isa_irq(isa_irq)
    );

    // Reference model state.
    int seen_m [12];
    int glob_m [12];
    int bm_m [16][12];
    logic [15:0] exp_out = '0;

    function automatic int src_line_of(int s);
        if (s < 8) return int'(func_line[s*8 +: 8]);
        case (s)
            8:  return int'(rt_cfg_lo[7:4]);
            9:  return int'(rt_cfg_mid[3:0]);
            10: return int'(rt_cfg_mid[7:4]);
            default: return int'(rt_cfg_hi[7:4]);
        endcase
    endfunction

    function automatic int src_level(int s);
        if (s < 8) return int'(func_level[s]);
        return int'(pin_level[s-8]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 12; s++) begin
                seen_m[s] = 0;
                glob_m[s] = 0;
                for (int k = 0; k < 16; k++) bm_m[k][s] = 0;
            end
        end else begin
            int pick;
            pick = -1;
            for (int s = 11; s >= 0; s--)
                if (src_level(s) != seen_m[s]) pick = s;
            if (pick >= 0) begin
                int l, n, top;
                l = src_level(pick);
                n = src_line_of(pick);
                seen_m[pick] = l;
                glob_m[pick] = l;
                top = (pick == 2 || pick == 3 || pick == 5) ? 14 : 15;
                if (n != 0 && n != 255 && n != 2 && n <= top) begin
                    bm_m[n][pick] = l;
                    for (int s = 0; s < 12; s++)
                        if (glob_m[s] == 0) bm_m[n][s] = 0;
                end
            end
        end
        for (int k = 0; k < 16; k++) begin
            exp_out[k] = 1'b0;
            for (int s = 0; s < 12; s++)
                if (bm_m[k][s] != 0) exp_out[k] = 1'b1;
        end
    end

    // Compares the design against the model on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (model_on) begin
            checks++;
            if (isa_irq !== exp_out) begin
                errors++;
                $display("FAIL %s model compare: actual=%h expected=%h", cur_req, isa_irq, exp_out);
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [15:0] expv);
        checks++;
        if (isa_irq !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, isa_irq, expv);
        end
    endtask

    task automatic set_line(int f, int v);
        func_line[f*8 +: 8] = 8'(v);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        check("R1", 16'h0000);
        model_on = 1;

        set_line(0, 4); set_line(1, 4); set_line(2, 14); set_line(3, 15);
        set_line(4, 15); set_line(5, 255); set_line(6, 2); set_line(7, 0);
        tick();

        cur_req = "R2";
        func_level[1] = 1'b1; tick(); check("R2", 16'h0010);
        cur_req = "R9";
        func_level[0] = 1'b1; tick();
        func_level[1] = 1'b0; tick(); check("R9", 16'h0010);
        func_level[0] = 1'b0; tick(); check("R9", 16'h0000);

        cur_req = "R6";
        func_level[2] = 1'b1; tick(); check("R6", 16'h4000);
        func_level[3] = 1'b1; tick(2); check("R6", 16'h4000);
        func_level[4] = 1'b1; tick(); check("R6", 16'hC000);
        func_level[4:2] = 3'b000; tick(4); check("R6", 16'h0000);

        cur_req = "R4";
        func_level[5] = 1'b1; func_level[7] = 1'b1; tick(4); check("R4", 16'h0000);
        cur_req = "R5";
        func_level[6] = 1'b1; tick(3); check("R5", 16'h0000);
        func_level[7:5] = 3'b000; tick(4);

        cur_req = "R3";
        rt_cfg_lo = 8'h3F; rt_cfg_mid = 8'h75; rt_cfg_hi = 8'h9A;
        pin_level[0] = 1'b1; tick(); check("R3", 16'h0008);
        pin_level[1] = 1'b1; tick(); check("R3", 16'h0028);
        pin_level[2] = 1'b1; tick(); check("R3", 16'h00A8);
        pin_level[3] = 1'b1; tick(); check("R3", 16'h02A8);
        pin_level = 4'h0; tick(5); check("R3", 16'h0000);
        cur_req = "R5";
        rt_cfg_mid = 8'h25;
        pin_level[2] = 1'b1; tick(2); check("R5", 16'h0000);
        pin_level[2] = 1'b0; tick(2);

        cur_req = "R8";
        func_level[1] = 1'b1; func_level[4] = 1'b1; pin_level[0] = 1'b1;
        tick(); check("R8", 16'h0010);
        tick(); check("R8", 16'h8010);
        tick(); check("R8", 16'h8018);
        func_level[4] = 1'b0; pin_level[0] = 1'b0; tick(3); check("R8", 16'h0010);

        cur_req = "R7";
        set_line(1, 6);
        func_level[1] = 1'b0; tick(2); check("R7", 16'h0010);
        func_level[0] = 1'b1; tick(); check("R7", 16'h0010);
        func_level[0] = 1'b0; tick(); check("R7", 16'h0000);

        cur_req = "R1";
        func_level[2] = 1'b1; tick(2);
        rst_n = 1'b0; model_on = 0; tick(2);
        check("R1", 16'h0000);
        func_level[2] = 1'b0; tick();
        rst_n = 1'b1; model_on = 1; tick(2);
        check("R1", 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule